// File: doc/BRIEF.md
# Write Data De-interleaver for ID-Tagged Bursts

This block joins a write master that may interleave the data beats of several bursts with a write slave that takes each burst's data as one unbroken run. The master tags every data beat with a transaction ID. The slave's data channel carries no ID. Each accepted write address claims a buffer slot. Slots are claimed in a fixed ring order, so the order of the slots is the order in which addresses were accepted. Each incoming data beat goes to the oldest open slot whose ID matches the ID on the beat.

Once a slot holds every beat of its burst and its address has gone out downstream, the block sends the whole burst back to back with the last-beat flag on the final beat. It then frees the slot. Write addresses are forwarded downstream unchanged and in acceptance order. The write response channel passes straight through.

A data beat can arrive before its address. Such a beat waits with ready low until its address is accepted, so it is never dropped.

Top module: `axi3_wdeint`

## Requirements
- R1: Downstream write addresses appear in the order they were accepted upstream, with ID, address and length unchanged. While not accepted, an address holds its valid and its fields.
- R2: An upstream data beat goes to the oldest outstanding burst that has the same ID and still lacks beats. Beats of that burst keep their arrival order.
- R3: No more than NSLOT addresses (default 4) are outstanding. While NSLOT are held, upstream address ready stays low.
- R4: Downstream data carries no ID. Bursts leave in address-acceptance order, and no beat of another burst lies between two beats of one burst. Data and byte strobes are unchanged.
- R5: The downstream last flag is high only on beat number LEN of a burst, where LEN is the 4-bit length field (beats = LEN+1). A slot is released only when that last beat is accepted downstream.
- R6: An upstream data beat whose ID matches no open burst sees ready low. It is accepted only after a matching address has been taken.
- R7: While downstream data valid is high and ready is low, the data beat holds its data, strobes and last flag.
- R8: The response channel is passed through combinationally: valid, ID and the 2-bit response go upstream, and ready comes back downstream.
- R9: A burst starts downstream only once all its beats are buffered. After any non-last beat is accepted, downstream data valid is high in the next cycle.
- R10: After reset, upstream address ready is high, upstream data ready is low, and neither downstream valid is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_aw_valid | input | 1 | Upstream address valid |
| s_aw_ready | output | 1 | Upstream address ready |
| s_aw_id | input | IDW | Upstream address ID |
| s_aw_addr | input | ADDRW | Upstream address |
| s_aw_len | input | 4 | Upstream burst length minus one |
| s_w_valid | input | 1 | Upstream data valid |
| s_w_ready | output | 1 | Upstream data ready |
| s_w_id | input | IDW | Upstream data ID |
| s_w_data | input | DATAW | Upstream data |
| s_w_strb | input | DATAW/8 | Upstream byte strobes |
| s_w_last | input | 1 | Upstream last beat |
| m_aw_valid | output | 1 | Downstream address valid |
| m_aw_ready | input | 1 | Downstream address ready |
| m_aw_id | output | IDW | Downstream address ID |
| m_aw_addr | output | ADDRW | Downstream address |
| m_aw_len | output | 4 | Downstream burst length minus one |
| m_w_valid | output | 1 | Downstream data valid |
| m_w_ready | input | 1 | Downstream data ready |
| m_w_data | output | DATAW | Downstream data |
| m_w_strb | output | DATAW/8 | Downstream byte strobes |
| m_w_last | output | 1 | Downstream last beat |
| m_b_valid | input | 1 | Downstream response valid |
| m_b_ready | output | 1 | Downstream response ready |
| m_b_id | input | IDW | Downstream response ID |
| m_b_resp | input | 2 | Downstream response code |
| s_b_valid | output | 1 | Upstream response valid |
| s_b_ready | input | 1 | Upstream response ready |
| s_b_id | output | IDW | Upstream response ID |
| s_b_resp | output | 2 | Upstream response code |

## Verification
The assertions assume a well-behaved upstream master:
- Its last flag agrees with the length of the burst it belongs to.
- Lengths fit in MAXB beats.
- Bursts that share an ID are never interleaved.
- The first beats of interleaved bursts follow address order.

The stimulus meets these rules by building groups of up to four transactions with distinct IDs. Within a group, each burst is started in address order and beats are interleaved at random. Groups are sent one after another, so IDs that repeat across groups never overlap. Address and data streams run independently, and data often runs ahead of its address. Downstream ready is toggled at random.

// File: rtl/wdi_pkg.sv
package wdi_pkg;
   localparam int LEN_W  = 4;
   localparam int RESP_W = 2;
   typedef logic [LEN_W-1:0]  axlen_t;
   typedef logic [RESP_W-1:0] resp_t;
endpackage

// File: rtl/wdi_match.sv
module wdi_match #(
   parameter int NSLOT = 4,
   parameter int IDW   = 4,
   localparam int PW   = $clog2(NSLOT)
) (
   input  logic [NSLOT-1:0]          open_i,
   input  logic [NSLOT-1:0][IDW-1:0] id_i,
   input  logic [PW-1:0]             head_i,
   input  logic [IDW-1:0]            w_id_i,
   output logic                      hit_o,
   output logic [PW-1:0]             idx_o
);
   // Scan from youngest to oldest so the oldest open match wins.
   always_comb begin
      logic [PW-1:0] j;
      hit_o = 1'b0;
      idx_o = '0;
      for (int k = NSLOT - 1; k >= 0; k--) begin
         j = head_i + PW'(k);
         if (open_i[j] && (id_i[j] == w_id_i)) begin
            hit_o = 1'b1;
            idx_o = j;
         end
      end
   end
endmodule

// File: rtl/wdi_store.sv
module wdi_store #(
   parameter int NSLOT = 4,
   parameter int MAXB  = 16,
   parameter int DATAW = 32,
   localparam int SW   = DATAW / 8,
   localparam int PW   = $clog2(NSLOT),
   localparam int BW   = $clog2(MAXB)
) (
   input  logic             clk,
   input  logic             wr_en,
   input  logic [PW-1:0]    wr_slot,
   input  logic [BW-1:0]    wr_beat,
   input  logic [DATAW-1:0] wr_data,
   input  logic [SW-1:0]    wr_strb,
   input  logic [PW-1:0]    rd_slot,
   input  logic [BW-1:0]    rd_beat,
   output logic [DATAW-1:0] rd_data,
   output logic [SW-1:0]    rd_strb
);
   logic [NSLOT-1:0][DATAW-1:0] slot_data;
   logic [NSLOT-1:0][SW-1:0]    slot_strb;

   for (genvar s = 0; s < NSLOT; s++) begin : g_bank
      logic [DATAW-1:0] d_mem [MAXB];
      logic [SW-1:0]    s_mem [MAXB];
      always_ff @(posedge clk) begin
         if (wr_en && (wr_slot == PW'(s))) begin
            d_mem[wr_beat] <= wr_data;
            s_mem[wr_beat] <= wr_strb;
         end
      end
      assign slot_data[s] = d_mem[rd_beat];
      assign slot_strb[s] = s_mem[rd_beat];
   end

   assign rd_data = slot_data[rd_slot];
   assign rd_strb = slot_strb[rd_slot];
endmodule

// File: rtl/axi3_wdeint.sv
module axi3_wdeint
   import wdi_pkg::*;
#(
   parameter int IDW   = 4,
   parameter int ADDRW = 32,
   parameter int DATAW = 32,
   parameter int NSLOT = 4,
   parameter int MAXB  = 16,
   localparam int SW   = DATAW / 8,
   localparam int PW   = $clog2(NSLOT),
   localparam int CW   = $clog2(NSLOT + 1),
   localparam int BW   = $clog2(MAXB),
   localparam int FW   = BW + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             s_aw_valid,
   output logic             s_aw_ready,
   input  logic [IDW-1:0]   s_aw_id,
   input  logic [ADDRW-1:0] s_aw_addr,
   input  logic [3:0]       s_aw_len,
   input  logic             s_w_valid,
   output logic             s_w_ready,
   input  logic [IDW-1:0]   s_w_id,
   input  logic [DATAW-1:0] s_w_data,
   input  logic [SW-1:0]    s_w_strb,
   input  logic             s_w_last,
   output logic             m_aw_valid,
   input  logic             m_aw_ready,
   output logic [IDW-1:0]   m_aw_id,
   output logic [ADDRW-1:0] m_aw_addr,
   output logic [3:0]       m_aw_len,
   output logic             m_w_valid,
   input  logic             m_w_ready,
   output logic [DATAW-1:0] m_w_data,
   output logic [SW-1:0]    m_w_strb,
   output logic             m_w_last,
   input  logic             m_b_valid,
   output logic             m_b_ready,
   input  logic [IDW-1:0]   m_b_id,
   input  logic [1:0]       m_b_resp,
   output logic             s_b_valid,
   input  logic             s_b_ready,
   output logic [IDW-1:0]   s_b_id,
   output logic [1:0]       s_b_resp
);
   initial begin
      if (NSLOT < 2 || (NSLOT & (NSLOT - 1)) != 0)
         $error("NSLOT must be a power of two of at least 2");
      if (MAXB < 2 || MAXB > 16 || (MAXB & (MAXB - 1)) != 0)
         $error("MAXB must be a power of two from 2 to 16");
      if (DATAW % 8 != 0)
         $error("DATAW must be a whole number of bytes");
   end

   // Slot state
   logic [NSLOT-1:0]            sl_busy;
   logic [NSLOT-1:0][IDW-1:0]   sl_id;
   logic [NSLOT-1:0][ADDRW-1:0] sl_addr;
   logic [NSLOT-1:0][3:0]       sl_len;
   logic [NSLOT-1:0][FW-1:0]    sl_fill;
   logic [NSLOT-1:0]            sl_open;

   logic [PW-1:0] wp, rp, awp;
   logic [CW-1:0] cnt_alloc, cnt_unfwd;
   logic [BW-1:0] rd_beat;

   logic          hit;
   logic [PW-1:0] hit_idx;
   logic          aw_fire, maw_fire, w_fire, mw_fire, drain_done;

   for (genvar k = 0; k < NSLOT; k++) begin : g_open
      assign sl_open[k] = sl_busy[k] && (sl_fill[k] <= FW'(sl_len[k]));
   end

   wdi_match #(.NSLOT(NSLOT), .IDW(IDW)) u_match (
      .open_i (sl_open),
      .id_i   (sl_id),
      .head_i (rp),
      .w_id_i (s_w_id),
      .hit_o  (hit),
      .idx_o  (hit_idx)
   );

   // Upstream side
   assign s_aw_ready = (cnt_alloc != CW'(NSLOT));
   assign aw_fire    = s_aw_valid && s_aw_ready;
   assign s_w_ready  = hit;
   assign w_fire     = s_w_valid && hit;

   // Downstream address: oldest slot not yet forwarded
   assign m_aw_valid = (cnt_unfwd != '0);
   assign m_aw_id    = sl_id[awp];
   assign m_aw_addr  = sl_addr[awp];
   assign m_aw_len   = sl_len[awp];
   assign maw_fire   = m_aw_valid && m_aw_ready;

   // Downstream data: head slot, forwarded and fully buffered
   assign m_w_valid  = ((cnt_alloc - cnt_unfwd) != '0) && sl_busy[rp] &&
                       (sl_fill[rp] == (FW'(sl_len[rp]) + FW'(1)));
   assign m_w_last   = (rd_beat == BW'(sl_len[rp]));
   assign mw_fire    = m_w_valid && m_w_ready;
   assign drain_done = mw_fire && m_w_last;

   wdi_store #(.NSLOT(NSLOT), .MAXB(MAXB), .DATAW(DATAW)) u_store (
      .clk     (clk),
      .wr_en   (w_fire),
      .wr_slot (hit_idx),
      .wr_beat (sl_fill[hit_idx][BW-1:0]),
      .wr_data (s_w_data),
      .wr_strb (s_w_strb),
      .rd_slot (rp),
      .rd_beat (rd_beat),
      .rd_data (m_w_data),
      .rd_strb (m_w_strb)
   );

   // Response pass-through
   assign s_b_valid = m_b_valid;
   assign s_b_id    = m_b_id;
   assign s_b_resp  = m_b_resp;
   assign m_b_ready = s_b_ready;

   for (genvar k = 0; k < NSLOT; k++) begin : g_slot
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            sl_busy[k] <= 1'b0;
            sl_fill[k] <= '0;
            sl_id[k]   <= '0;
            sl_addr[k] <= '0;
            sl_len[k]  <= '0;
         end else if (aw_fire && (wp == PW'(k))) begin
            sl_busy[k] <= 1'b1;
            sl_fill[k] <= '0;
            sl_id[k]   <= s_aw_id;
            sl_addr[k] <= s_aw_addr;
            sl_len[k]  <= s_aw_len;
         end else begin
            if (w_fire && (hit_idx == PW'(k)))
               sl_fill[k] <= sl_fill[k] + FW'(1);
            if (drain_done && (rp == PW'(k)))
               sl_busy[k] <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp        <= '0;
         rp        <= '0;
         awp       <= '0;
         rd_beat   <= '0;
         cnt_alloc <= '0;
         cnt_unfwd <= '0;
      end else begin
         if (aw_fire)  wp  <= wp + PW'(1);
         if (maw_fire) awp <= awp + PW'(1);
         if (drain_done) begin
            rp      <= rp + PW'(1);
            rd_beat <= '0;
         end else if (mw_fire) begin
            rd_beat <= rd_beat + BW'(1);
         end
         cnt_alloc <= cnt_alloc + CW'(aw_fire) - CW'(drain_done);
         cnt_unfwd <= cnt_unfwd + CW'(aw_fire) - CW'(maw_fire);
      end
   end

   // Assertions
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_alloc <= CW'(NSLOT)) && (cnt_unfwd <= cnt_alloc)); // R3
   AST_AW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      m_aw_valid && !m_aw_ready |=> m_aw_valid && $stable(m_aw_id) &&
      $stable(m_aw_addr) && $stable(m_aw_len)); // R1
   AST_W_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      m_w_valid && !m_w_ready |=> m_w_valid && $stable(m_w_data) &&
      $stable(m_w_strb) && $stable(m_w_last)); // R7
   AST_BURST_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      m_w_valid && m_w_ready && !m_w_last |=> m_w_valid); // R9
   AST_W_NEEDS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      s_w_valid && s_w_ready |-> cnt_alloc != '0); // R6
   AST_LAST_AGREES: assert property (@(posedge clk) disable iff (!rst_n)
      w_fire |-> (s_w_last == (sl_fill[hit_idx] == FW'(sl_len[hit_idx])))); // R5
endmodule

// File: tb/axi3_wdeint_tb.sv
module axi3_wdeint_tb;
   localparam int IDW = 4, ADDRW = 32, DATAW = 32, SW = 4;
   localparam int NTX = 40;

   logic clk = 1'b0, rst_n = 1'b0;
   always #10 clk = ~clk;   // 50 MHz

   logic             s_aw_valid = 0, s_aw_ready;
   logic [IDW-1:0]   s_aw_id = 0;
   logic [ADDRW-1:0] s_aw_addr = 0;
   logic [3:0]       s_aw_len = 0;
   logic             s_w_valid = 0, s_w_ready;
   logic [IDW-1:0]   s_w_id = 0;
   logic [DATAW-1:0] s_w_data = 0;
   logic [SW-1:0]    s_w_strb = 0;
   logic             s_w_last = 0;
   logic             m_aw_valid, m_aw_ready = 1;
   logic [IDW-1:0]   m_aw_id;
   logic [ADDRW-1:0] m_aw_addr;
   logic [3:0]       m_aw_len;
   logic             m_w_valid, m_w_ready = 1;
   logic [DATAW-1:0] m_w_data;
   logic [SW-1:0]    m_w_strb;
   logic             m_w_last;
   logic             m_b_valid = 0, m_b_ready;
   logic [IDW-1:0]   m_b_id = 0;
   logic [1:0]       m_b_resp = 0;
   logic             s_b_valid, s_b_ready = 0;
   logic [IDW-1:0]   s_b_id;
   logic [1:0]       s_b_resp;

   axi3_wdeint u_dut (.*);

   int errors = 0, checks = 0;
   int bp_mode = 0;       // 0 ready, 1 random, 2 data stalled
   bit finished = 0;
   bit mon_en = 0;
   int tid  [NTX];
   int tlen [NTX];
   int aw_out_n = 0, w_out_t = 0, w_out_b = 0;

   function automatic logic [31:0] f_data(int t, int b);
      return (32'h9E37_79B9 * (t * 17 + b + 1)) ^ {t[7:0], b[7:0], 16'h5AC3};
   endfunction
   function automatic logic [3:0] f_strb(int t, int b);
      logic [31:0] v = f_data(t, b);
      return v[7:4] ^ v[19:16];
   endfunction
   function automatic logic [31:0] f_addr(int t);
      return 32'h1000_0000 + t * 32'h40;
   endfunction

   task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
      end
   endtask

   task automatic aw_send(int t);
      @(posedge clk); #1;
      s_aw_valid = 1; s_aw_id = tid[t][IDW-1:0];
      s_aw_addr = f_addr(t); s_aw_len = tlen[t][3:0];
      forever begin @(negedge clk); if (s_aw_ready) break; end
      @(posedge clk); #1; s_aw_valid = 0;
   endtask

   task automatic w_send(int t, int b);
      @(posedge clk); #1;
      s_w_valid = 1; s_w_id = tid[t][IDW-1:0];
      s_w_data = f_data(t, b); s_w_strb = f_strb(t, b);
      s_w_last = (b == tlen[t]);
      forever begin @(negedge clk); if (s_w_ready) break; end
      @(posedge clk); #1; s_w_valid = 0;
   endtask

   task automatic drive_group(int base, int g);
      int nx [4] = '{default: 0};
      int started = 0, ndone = 0;
      while (ndone < g) begin
         int r = (started < g) ? int'($urandom % (started + 1)) : int'($urandom % started);
         int k;
         if (r == started) begin k = started; started++; end
         else k = r;
         if (nx[k] > tlen[base + k]) continue;
         w_send(base + k, nx[k]);
         nx[k]++;
         if (nx[k] > tlen[base + k]) ndone++;
         repeat ($urandom % 2) @(posedge clk);
      end
   endtask

   // Downstream ready generator
   initial begin
      forever begin
         @(posedge clk); #1;
         case (bp_mode)
            1: begin m_w_ready = ($urandom % 4) != 0; m_aw_ready = ($urandom % 3) != 0; end
            2: begin m_w_ready = 0; m_aw_ready = 1; end
            default: begin m_w_ready = 1; m_aw_ready = 1; end
         endcase
      end
   end

   // Monitor
   initial begin
      bit pend_run = 0, pend_hold = 0;
      logic [31:0] hd; logic [3:0] hs; logic hl;
      forever begin
         @(negedge clk);
         if (mon_en) begin
            if (pend_run) check(m_w_valid, "R9", "valid after non-last beat", m_w_valid, 1);
            if (pend_hold)
               check(m_w_valid && m_w_data == hd && m_w_strb == hs && m_w_last == hl,
                     "R7", "data held under stall", m_w_data, hd);
            pend_run = 0; pend_hold = 0;
            if (m_aw_valid && m_aw_ready) begin
               if (aw_out_n < NTX)
                  check(m_aw_id == tid[aw_out_n][IDW-1:0] && m_aw_addr == f_addr(aw_out_n) &&
                        m_aw_len == tlen[aw_out_n][3:0], "R1", "address order/fields",
                        {m_aw_id, m_aw_len, m_aw_addr}, {tid[aw_out_n][3:0], tlen[aw_out_n][3:0], f_addr(aw_out_n)});
               else check(0, "R1", "extra address", aw_out_n, NTX);
               aw_out_n++;
            end
            if (m_w_valid && m_w_ready) begin
               if (w_out_t < NTX) begin
                  check(m_w_data == f_data(w_out_t, w_out_b) && m_w_strb == f_strb(w_out_t, w_out_b),
                        "R2 R4", "data beat", {m_w_strb, m_w_data}, {f_strb(w_out_t, w_out_b), f_data(w_out_t, w_out_b)});
                  check(m_w_last == (w_out_b == tlen[w_out_t]), "R5", "last flag", m_w_last, (w_out_b == tlen[w_out_t]));
                  if (!m_w_last) pend_run = 1;
                  if (w_out_b == tlen[w_out_t]) begin w_out_t++; w_out_b = 0; end
                  else w_out_b++;
               end else check(0, "R4", "extra data beat", w_out_t, NTX);
            end else if (m_w_valid && !m_w_ready) begin
               pend_hold = 1; hd = m_w_data; hs = m_w_strb; hl = m_w_last;
            end
         end
      end
   end

   // Watchdog
   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         errors++; checks++;
         $display("FAIL watchdog act=%0d exp=%0d", w_out_t, NTX);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      int seed = $urandom(32'd2024);
      for (int t = 0; t < NTX; t++) begin
         tid[t]  = (t % 4) + 4 * int'($urandom % 4);
         tlen[t] = int'($urandom % 16);
      end
      tlen[0] = 0; tlen[1] = 3; tlen[2] = 0; tlen[3] = 15; tlen[4] = 7;

      repeat (3) @(posedge clk); #1; rst_n = 1;
      @(negedge clk);
      check(s_aw_ready == 1, "R10", "reset aw ready", s_aw_ready, 1);
      check(s_w_ready == 0, "R10", "reset w ready", s_w_ready, 0);
      check(m_aw_valid == 0 && m_w_valid == 0, "R10", "reset out valid", {m_aw_valid, m_w_valid}, 0);
      mon_en = 1;

      // R8: response pass-through
      for (int i = 0; i < 3; i++) begin
         logic [3:0] bi = 4'($urandom); logic [1:0] br = 2'($urandom);
         logic bv = 1'(i != 1); logic rr = 1'(i != 2);
         m_b_valid = bv; m_b_id = bi; m_b_resp = br; s_b_ready = rr; #1;
         check(s_b_valid == bv && s_b_id == bi && s_b_resp == br && m_b_ready == rr,
               "R8", "response pass", {s_b_valid, s_b_id, s_b_resp, m_b_ready}, {bv, bi, br, rr});
      end
      m_b_valid = 0;

      // R6: data before address is held
      fork
         w_send(0, 0);
         begin
            repeat (5) begin
               @(negedge clk);
               check(s_w_ready == 0, "R6", "early data held", s_w_ready, 0);
            end
            aw_send(0);
         end
      join
      repeat (10) @(posedge clk);

      // R3: four outstanding addresses without data stall the address port
      for (int t = 1; t <= 4; t++) aw_send(t);
      repeat (3) @(negedge clk);
      check(s_aw_ready == 0, "R3", "aw stall at limit", s_aw_ready, 0);
      bp_mode = 2;
      drive_group(1, 4);
      repeat (4) @(negedge clk);
      check(s_aw_ready == 0, "R5", "slots kept until drained", s_aw_ready, 0);
      check(m_w_valid == 1, "R9", "complete burst offered", m_w_valid, 1);
      bp_mode = 0;
      wait (w_out_t == 5);
      repeat (2) @(negedge clk);
      check(s_aw_ready == 1, "R5", "slots freed after drain", s_aw_ready, 1);

      // Random phase
      bp_mode = 1;
      fork
         for (int t = 5; t < NTX; t++) begin
            repeat ($urandom % 4) @(posedge clk);
            aw_send(t);
         end
         begin
            int t = 5;
            while (t < NTX) begin
               int g = 1 + int'($urandom % 4);
               if (t + g > NTX) g = NTX - t;
               drive_group(t, g);
               t += g;
            end
         end
      join
      wait (w_out_t == NTX);
      repeat (5) @(negedge clk);
      check(aw_out_n == NTX, "R1", "address count", aw_out_n, NTX);
      check(m_w_valid == 0, "R4", "no stray data", m_w_valid, 0);
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule